// File: doc/BRIEF.md
# Cascaded Edge/Level Interrupt Request Latch

This block sits at the front of a two-stage interrupt controller pair. It collects sixteen interrupt lines and turns them into two eight-bit request vectors. Lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary one. Each line may be driven by several sources, and the line counts as active while any of its sources is high. A per-controller trigger register chooses, for each line, whether the request bit follows edges or levels. Some lines are hard-wired to edge behaviour.

The block also links the two controllers. When the secondary's priority logic reports a pending level, the block raises the secondary's flag once and sends a single-cycle pulse into primary line 2. When the primary's priority logic reports a pending level, the block raises the primary interrupt output. An acknowledge vector in the secondary's range is applied to both controllers. Any other acknowledge vector is applied to the primary only. Priority resolution and command decoding are done outside this block and arrive as eligibility and readiness inputs.

Top module: `irqCascLatch`

## Requirements
- R1: In edge mode (trigger bit 0), a rising edge on a line sets its request bit. A falling edge leaves the bit set.
- R2: In level mode (trigger bit 1), the request bit is set in every cycle the line is high and cleared on the cycle the line falls.
- R3: Both trigger registers reset to 0x00 and can be read back. Writes (trigWrSel 0 for primary, 1 for secondary) keep only the bits in mask 0xF8 for the primary and 0xDE for the secondary. This means lines 0, 1, 2, 8 and 13 always stay edge-triggered.
- R4: While a controller's ready input is low, line changes do not alter its request bits. An edge that occurs while not ready is lost.
- R5: Line n is active when any of its sources irqSrc[n*SRCS_PER_LINE + s] is high.
- R6: When slaveEligible is high and slaveRaised is low, slaveRaised and cascadePulse go high on the next edge. cascadePulse lasts exactly one cycle, and it sets primary request bit 2 on the following edge.
- R7: masterIntr rises on the edge after masterEligible is seen while masterIntr is low. It then stays high until an acknowledge arrives.
- R8: An acknowledge whose vector bits [7:3] equal slaveBase is applied to secondary pin vector[2:0] and to primary pin 2, and it clears both slaveRaised and masterIntr. Any other acknowledge is applied to primary pin vector[2:0] and clears only masterIntr.
- R9: An acknowledge applied to a pin clears that pin's request bit only if the line is inactive in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqSrc | input | 16*SRCS_PER_LINE | Interrupt sources; bit n*SRCS_PER_LINE+s is source s of line n |
| readyMaster | input | 1 | Primary controller initialised |
| readySlave | input | 1 | Secondary controller initialised |
| trigWrEn | input | 1 | Trigger register write strobe |
| trigWrSel | input | 1 | 0 selects the primary trigger register, 1 the secondary |
| trigWrData | input | 8 | Trigger write data, 1 = level |
| slaveEligible | input | 1 | Secondary has a pending unmasked level |
| masterEligible | input | 1 | Primary has a pending unmasked level |
| slaveBase | input | 5 | Upper vector bits assigned to the secondary |
| ackValid | input | 1 | Acknowledge strobe |
| ackVector | input | 8 | Acknowledged vector |
| reqMaster | output | 8 | Primary request bits |
| reqSlave | output | 8 | Secondary request bits |
| trigMaster | output | 8 | Primary trigger register |
| trigSlave | output | 8 | Secondary trigger register |
| masterIntr | output | 1 | Primary raised flag / interrupt output |
| slaveRaised | output | 1 | Secondary raised flag |
| cascadePulse | output | 1 | One-cycle cascade pulse into primary line 2 |

## Verification
Several properties are checked in every cycle:
- the fixed edge-only bits never read back as 1;
- request vectors do not move while their controller is not ready;
- in all-edge mode, request bits are never cleared without an acknowledge;
- the cascade pulse lasts exactly one cycle and coincides with the secondary's flag rising;
- both raised flags respond correctly to acknowledges.

Other behaviour can only be shown by the bench's scenarios:
- level clearing on a falling line;
- source merging on a shared line;
- loss of an edge seen while not ready;
- the cascade pulse landing in primary request bit 2;
- the line-still-active rule when an acknowledge arrives.

// File: rtl/irqCascPkg.sv
package irqCascPkg;
  localparam int CTL_LINES   = 8;
  localparam int NUM_LINES   = 2 * CTL_LINES;
  localparam int PIN_W       = $clog2(CTL_LINES);
  localparam int CASCADE_PIN = 2;
  localparam logic [CTL_LINES-1:0] MASTER_TRIG_MASK = 8'hF8;
  localparam logic [CTL_LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE;

  typedef struct packed {
    logic             ackMasterEn;
    logic [PIN_W-1:0] ackMasterPin;
    logic             ackSlaveEn;
    logic [PIN_W-1:0] ackSlavePin;
    logic             cascadePulse;
  } ctlStrobes_t;
endpackage

// File: rtl/irqReqBank.sv
module irqReqBank #(
  parameter int LINES = 8,
  parameter int PIN_W = $clog2(LINES),
  parameter logic [LINES-1:0] TRIG_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ready,
  input  logic [LINES-1:0] lineIn,
  input  logic             trigWrEn,
  input  logic [LINES-1:0] trigWrData,
  input  logic             ackEn,
  input  logic [PIN_W-1:0] ackPin,
  output logic [LINES-1:0] reqOut,
  output logic [LINES-1:0] trigOut
);
  logic [LINES-1:0] trigReg;
  logic [LINES-1:0] prevLine;
  logic [LINES-1:0] reqReg;
  logic [LINES-1:0] reqNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigReg  <= '0;
      prevLine <= '0;
      reqReg   <= '0;
    end else begin
      if (trigWrEn) trigReg <= trigWrData & TRIG_MASK;
      prevLine <= lineIn;
      reqReg   <= reqNext;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic rise, fall, isLevel, ackHit;
    assign rise    = lineIn[i] & ~prevLine[i];
    assign fall    = ~lineIn[i] & prevLine[i];
    assign isLevel = trigReg[i];
    assign ackHit  = ackEn && (ackPin == PIN_W'(i)) && !lineIn[i];
    always_comb begin
      reqNext[i] = reqReg[i];
      if (ready) begin
        if (isLevel) begin
          if (lineIn[i])  reqNext[i] = 1'b1;
          else if (fall)  reqNext[i] = 1'b0;
        end else if (rise) begin
          reqNext[i] = 1'b1;
        end
      end
      if (ackHit) reqNext[i] = 1'b0;
    end
  end

  assign reqOut  = reqReg;
  assign trigOut = trigReg;
endmodule

// File: rtl/irqReqDatapath.sv
module irqReqDatapath
  import irqCascPkg::*;
#(
  parameter int SRCS_PER_LINE = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0] irqSrc,
  input  logic                               readyMaster,
  input  logic                               readySlave,
  input  logic                               trigWrEn,
  input  logic                               trigWrSel,
  input  logic [CTL_LINES-1:0]               trigWrData,
  input  ctlStrobes_t                        strb,
  output logic [CTL_LINES-1:0]               reqMaster,
  output logic [CTL_LINES-1:0]               reqSlave,
  output logic [CTL_LINES-1:0]               trigMaster,
  output logic [CTL_LINES-1:0]               trigSlave
);
  logic [NUM_LINES-1:0] lineAny;
  logic [CTL_LINES-1:0] masterLine;
  logic [CTL_LINES-1:0] slaveLine;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_merge
    assign lineAny[n] = |irqSrc[n*SRCS_PER_LINE +: SRCS_PER_LINE];
  end

  assign masterLine = lineAny[CTL_LINES-1:0]
                    | (CTL_LINES'(strb.cascadePulse) << CASCADE_PIN);
  assign slaveLine  = lineAny[NUM_LINES-1:CTL_LINES];

  irqReqBank #(
    .LINES(CTL_LINES), .PIN_W(PIN_W), .TRIG_MASK(MASTER_TRIG_MASK)
  ) masterBank_i (
    .clk(clk), .rstN(rstN), .ready(readyMaster), .lineIn(masterLine),
    .trigWrEn(trigWrEn && !trigWrSel), .trigWrData(trigWrData),
    .ackEn(strb.ackMasterEn), .ackPin(strb.ackMasterPin),
    .reqOut(reqMaster), .trigOut(trigMaster)
  );

  irqReqBank #(
    .LINES(CTL_LINES), .PIN_W(PIN_W), .TRIG_MASK(SLAVE_TRIG_MASK)
  ) slaveBank_i (
    .clk(clk), .rstN(rstN), .ready(readySlave), .lineIn(slaveLine),
    .trigWrEn(trigWrEn && trigWrSel), .trigWrData(trigWrData),
    .ackEn(strb.ackSlaveEn), .ackPin(strb.ackSlavePin),
    .reqOut(reqSlave), .trigOut(trigSlave)
  );
endmodule

// File: rtl/irqCascCtrl.sv
module irqCascCtrl
  import irqCascPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int BASE_W = VEC_W - PIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveEligible,
  input  logic              masterEligible,
  input  logic [BASE_W-1:0] slaveBase,
  input  logic              ackValid,
  input  logic [VEC_W-1:0]  ackVector,
  output ctlStrobes_t       strb,
  output logic              masterIntr,
  output logic              slaveRaised
);
  logic masterRaisedReg, slaveRaisedReg, cascReg;
  logic ackIsSlave, slaveFire, masterFire;

  assign ackIsSlave = ackValid && (ackVector[VEC_W-1:PIN_W] == slaveBase);
  assign slaveFire  = !ackIsSlave && !slaveRaisedReg && slaveEligible;
  assign masterFire = !ackValid && !masterRaisedReg && masterEligible;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterRaisedReg <= 1'b0;
      slaveRaisedReg  <= 1'b0;
      cascReg         <= 1'b0;
    end else begin
      cascReg <= slaveFire;
      if (ackIsSlave)     slaveRaisedReg <= 1'b0;
      else if (slaveFire) slaveRaisedReg <= 1'b1;
      if (ackValid)        masterRaisedReg <= 1'b0;
      else if (masterFire) masterRaisedReg <= 1'b1;
    end
  end

  always_comb begin
    strb.ackMasterEn  = ackValid;
    strb.ackMasterPin = ackIsSlave ? PIN_W'(CASCADE_PIN) : ackVector[PIN_W-1:0];
    strb.ackSlaveEn   = ackIsSlave;
    strb.ackSlavePin  = ackVector[PIN_W-1:0];
    strb.cascadePulse = cascReg;
  end

  assign masterIntr  = masterRaisedReg;
  assign slaveRaised = slaveRaisedReg;
endmodule

// File: rtl/irqCascLatch.sv
module irqCascLatch
  import irqCascPkg::*;
#(
  parameter int SRCS_PER_LINE = 2,
  parameter int VEC_W         = 8,
  parameter int BASE_W        = VEC_W - PIN_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0] irqSrc,
  input  logic                               readyMaster,
  input  logic                               readySlave,
  input  logic                               trigWrEn,
  input  logic                               trigWrSel,
  input  logic [CTL_LINES-1:0]               trigWrData,
  input  logic                               slaveEligible,
  input  logic                               masterEligible,
  input  logic [BASE_W-1:0]                  slaveBase,
  input  logic                               ackValid,
  input  logic [VEC_W-1:0]                   ackVector,
  output logic [CTL_LINES-1:0]               reqMaster,
  output logic [CTL_LINES-1:0]               reqSlave,
  output logic [CTL_LINES-1:0]               trigMaster,
  output logic [CTL_LINES-1:0]               trigSlave,
  output logic                               masterIntr,
  output logic                               slaveRaised,
  output logic                               cascadePulse
);
  ctlStrobes_t strb;

  irqCascCtrl #(.VEC_W(VEC_W), .BASE_W(BASE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .slaveEligible(slaveEligible),
    .masterEligible(masterEligible), .slaveBase(slaveBase),
    .ackValid(ackValid), .ackVector(ackVector), .strb(strb),
    .masterIntr(masterIntr), .slaveRaised(slaveRaised)
  );

  irqReqDatapath #(.SRCS_PER_LINE(SRCS_PER_LINE)) dp_i (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .readyMaster(readyMaster),
    .readySlave(readySlave), .trigWrEn(trigWrEn), .trigWrSel(trigWrSel),
    .trigWrData(trigWrData), .strb(strb), .reqMaster(reqMaster),
    .reqSlave(reqSlave), .trigMaster(trigMaster), .trigSlave(trigSlave)
  );

  assign cascadePulse = strb.cascadePulse;
endmodule

// File: rtl/irqCascLatchChk.sv
module irqCascLatchChk
  import irqCascPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int BASE_W = VEC_W - PIN_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 readyMaster,
  input logic                 readySlave,
  input logic                 ackValid,
  input logic [VEC_W-1:0]     ackVector,
  input logic [BASE_W-1:0]    slaveBase,
  input logic [CTL_LINES-1:0] reqMaster,
  input logic [CTL_LINES-1:0] reqSlave,
  input logic [CTL_LINES-1:0] trigMaster,
  input logic [CTL_LINES-1:0] trigSlave,
  input logic                 masterIntr,
  input logic                 slaveRaised,
  input logic                 cascadePulse
);
  AST_TRIG_FIXED_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((trigMaster & ~MASTER_TRIG_MASK) == '0) && ((trigSlave & ~SLAVE_TRIG_MASK) == '0)); // R3
  AST_MASTER_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!readyMaster && !ackValid) |=> $stable(reqMaster)); // R4
  AST_SLAVE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!readySlave && !ackValid) |=> $stable(reqSlave)); // R4
  AST_EDGE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!ackValid && trigMaster == '0) |=> ((reqMaster & $past(reqMaster)) == $past(reqMaster))); // R1
  AST_CASC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cascadePulse |=> !cascadePulse); // R6
  AST_CASC_WITH_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slaveRaised) |-> cascadePulse); // R6
  AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (masterIntr && !ackValid) |=> masterIntr); // R7
  AST_ACK_CLR_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !masterIntr); // R8
  AST_ACK_CLR_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackVector[VEC_W-1:PIN_W] == slaveBase) |=> !slaveRaised); // R8
endmodule

bind irqCascLatch irqCascLatchChk #(.VEC_W(VEC_W), .BASE_W(BASE_W)) chk_i (
  .clk(clk), .rstN(rstN), .readyMaster(readyMaster), .readySlave(readySlave),
  .ackValid(ackValid), .ackVector(ackVector), .slaveBase(slaveBase),
  .reqMaster(reqMaster), .reqSlave(reqSlave), .trigMaster(trigMaster),
  .trigSlave(trigSlave), .masterIntr(masterIntr), .slaveRaised(slaveRaised),
  .cascadePulse(cascadePulse)
);

// File: tb/irqCascLatch_tb.sv
module irqCascLatch_tb_top;
  localparam int SRCS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16*SRCS-1:0] irqSrc = '0;
  logic        readyMaster = 1'b1, readySlave = 1'b1;
  logic        trigWrEn = 1'b0, trigWrSel = 1'b0;
  logic [7:0]  trigWrData = '0;
  logic        slaveEligible = 1'b0, masterEligible = 1'b0;
  logic [4:0]  slaveBase = 5'h0A;
  logic        ackValid = 1'b0;
  logic [7:0]  ackVector = '0;
  logic [7:0]  reqMaster, reqSlave, trigMaster, trigSlave;
  logic        masterIntr, slaveRaised, cascadePulse;

  int testsRun = 0, testsFailed = 0, cycles = 0;

  irqCascLatch #(.SRCS_PER_LINE(SRCS)) dut_i (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .readyMaster(readyMaster),
    .readySlave(readySlave), .trigWrEn(trigWrEn), .trigWrSel(trigWrSel),
    .trigWrData(trigWrData), .slaveEligible(slaveEligible),
    .masterEligible(masterEligible), .slaveBase(slaveBase),
    .ackValid(ackValid), .ackVector(ackVector), .reqMaster(reqMaster),
    .reqSlave(reqSlave), .trigMaster(trigMaster), .trigSlave(trigSlave),
    .masterIntr(masterIntr), .slaveRaised(slaveRaised), .cascadePulse(cascadePulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // {lines driven on source 0, expected {reqSlave, reqMaster}}
  localparam logic [31:0] VEC_TABLE [6] = '{
    {16'h0000, 16'h0000},
    {16'h2109, 16'h2109},
    {16'h0000, 16'h2101},
    {16'h8080, 16'hA181},
    {16'h8000, 16'hA101},
    {16'h0002, 16'h2103}
  };

  function automatic logic [16*SRCS-1:0] spread(input logic [15:0] lines);
    logic [16*SRCS-1:0] v = '0;
    for (int l = 0; l < 16; l++) v[l*SRCS] = lines[l];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; irqSrc = '0; ackValid = 1'b0; trigWrEn = 1'b0;
    slaveEligible = 1'b0; masterEligible = 1'b0;
    readyMaster = 1'b1; readySlave = 1'b1;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic trigWrite(input logic sel, input logic [7:0] data);
    trigWrEn = 1'b1; trigWrSel = sel; trigWrData = data;
    tick();
    trigWrEn = 1'b0;
  endtask

  task automatic ack(input logic [7:0] vec);
    ackValid = 1'b1; ackVector = vec;
    tick();
    ackValid = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // reset state
    check("R3 reset trig", {trigSlave, trigMaster}, 32'h0);
    check("R1 reset req", {reqSlave, reqMaster}, 32'h0);
    check("R7 reset flags", {masterIntr, slaveRaised, cascadePulse}, 32'h0);

    // R3 masking of write data
    trigWrite(1'b0, 8'hFF);
    check("R3 master mask", trigMaster, 32'hF8);
    trigWrite(1'b1, 8'hFF);
    check("R3 slave mask", trigSlave, 32'hDE);

    // table walk: R1 edge and R2 level behaviour
    for (int k = 0; k < 6; k++) begin
      irqSrc = spread(VEC_TABLE[k][31:16]);
      tick();
      check("R1/R2 table", {reqSlave, reqMaster}, VEC_TABLE[k][15:0]);
    end

    // R3 fixed bits stay edge-only
    doReset();
    trigWrite(1'b0, 8'h07);
    check("R3 master fixed", trigMaster, 32'h00);
    trigWrite(1'b1, 8'h21);
    check("R3 slave fixed", trigSlave, 32'h00);

    // R5 two sources on level line 4
    trigWrite(1'b0, 8'h10);
    irqSrc[4*SRCS] = 1'b1; irqSrc[4*SRCS+1] = 1'b1;
    tick();
    check("R5 both high", reqMaster, 32'h10);
    irqSrc[4*SRCS] = 1'b0;
    tick();
    check("R5 one source held", reqMaster, 32'h10);
    irqSrc[4*SRCS+1] = 1'b0;
    tick();
    check("R2 level fall clears", reqMaster, 32'h00);

    // R4 not ready
    doReset();
    readyMaster = 1'b0; readySlave = 1'b0;
    irqSrc = spread(16'h0101);
    tick(); tick();
    check("R4 ignored while not ready", {reqSlave, reqMaster}, 32'h0);
    readyMaster = 1'b1; readySlave = 1'b1;
    tick();
    check("R4 edge lost", {reqSlave, reqMaster}, 32'h0);
    irqSrc = '0; tick();
    irqSrc = spread(16'h0101); tick();
    check("R4 edge after ready", {reqSlave, reqMaster}, 32'h0101);

    // R6 cascade, R7 raise, R8 slave acknowledge
    doReset();
    slaveEligible = 1'b1;
    tick();
    check("R6 raise and pulse", {slaveRaised, cascadePulse, reqMaster}, {22'h0, 2'b11, 8'h00});
    tick();
    check("R6 pulse ends, master bit 2", {slaveRaised, cascadePulse, reqMaster}, {22'h0, 2'b10, 8'h04});
    tick();
    check("R6 no second pulse", cascadePulse, 32'h0);
    slaveEligible = 1'b0;
    masterEligible = 1'b1;
    tick();
    check("R7 masterIntr rises", masterIntr, 32'h1);
    masterEligible = 1'b0;
    tick();
    check("R7 masterIntr holds", masterIntr, 32'h1);
    irqSrc = spread(16'h0800); tick();
    irqSrc = '0; tick();
    check("R1 slave edge set", reqSlave, 32'h08);
    ack(8'h53);
    check("R8 slave ack", {slaveRaised, masterIntr, reqSlave, reqMaster}, {14'h0, 2'b00, 8'h00, 8'h00});

    // R8 primary acknowledge leaves secondary alone
    slaveEligible = 1'b1; tick();
    slaveEligible = 1'b0; tick();
    masterEligible = 1'b1; tick();
    masterEligible = 1'b0;
    irqSrc = spread(16'h0002); tick();
    irqSrc = '0; tick();
    check("R8 setup", {slaveRaised, masterIntr, reqMaster}, {22'h0, 2'b11, 8'h06});
    ack(8'h21);
    check("R8 master ack", {slaveRaised, masterIntr, reqMaster}, {22'h0, 2'b10, 8'h04});

    // R9 acknowledge with line still active
    irqSrc = spread(16'h0001); tick();
    check("R9 setup", reqMaster, 32'h05);
    ack(8'h20);
    check("R9 line high keeps request", reqMaster, 32'h05);
    irqSrc = '0; tick();
    check("R1 fall keeps edge request", reqMaster, 32'h05);
    ack(8'h20);
    check("R9 line low clears request", reqMaster, 32'h04);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule